// File: doc/BRIEF.md
# Sticky Flash Status Register

This block keeps the eight-bit status word of a flash program/erase controller and hands it to the read path. Each cycle it records whether the controller is busy and whether a program or an erase is suspended, and it gathers one-cycle error pulses into sticky flags. Those flags survive any number of later operations. Only a clear command or a hardware reset removes them.

A second path gives the bus a stable copy of the word. A small two-state machine, with the states SNAP_OPEN and SNAP_HELD, watches the active-low chip-enable and output-enable levels. The transition T_CAPTURE (SNAP_OPEN to SNAP_HELD) fires on the first cycle in which both enables are low, and it copies the live word into the snapshot. The transition T_RELEASE (SNAP_HELD to SNAP_OPEN) fires on any cycle in which either enable is high. The snapshot keeps its value between captures, so a host that wants a fresh value has to toggle one of the enables.

Live word layout: bit 7 is ready, bit 6 is erase-suspended, bit 5 is erase-failed, bit 4 is program-failed, bit 3 is supply-low, bit 2 is program-suspended, bit 1 is protect-violation, and bit 0 is always 0.

Top module: `flash_status_reg`

## Requirements
- R1: Bit 7 of `status_o` is 1 one cycle after `busy_i` is sampled 0, and 0 one cycle after `busy_i` is sampled 1.
- R2: Bit 6 follows `erase_susp_i` and bit 2 follows `prog_susp_i`, each with one cycle of delay. Both return to 0 when their input drops.
- R3: A pulse on `set_erase_fail_i`, `set_prog_fail_i`, `set_vpp_low_i` or `set_protect_i` makes bit 5, bit 4, bit 3 or bit 1 respectively equal to 1 one cycle later.
- R4: Bits 5, 4, 3 and 1 stay 1 through any change of `busy_i` or of the suspend inputs, as long as `clear_i` is 0.
- R5: `clear_i` makes bits 5, 4, 3 and 1 equal to 0 one cycle later. It leaves bits 7, 6 and 2 unchanged.
- R6: When a set pulse and `clear_i` arrive in the same cycle, the flag for that pulse is 1 afterwards. The other sticky flags are cleared.
- R7: Bit 0 of `status_o` and bit 0 of `read_o` are always 0.
- R8: On the first clock edge at which `ce_n_i` and `oe_n_i` are both sampled low after either was high (T_CAPTURE), `read_o` takes the value that `status_o` had just before that edge.
- R9: While `ce_n_i` and `oe_n_i` stay low, `read_o` does not change, even if `status_o` changes. Raising either enable and lowering it again takes a new snapshot.
- R10: When `rst_n` is low, `status_o` and `read_o` are 80h and the capture machine is in SNAP_OPEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| busy_i | input | 1 | Controller-active level |
| prog_susp_i | input | 1 | Program-suspended level |
| erase_susp_i | input | 1 | Erase-suspended level |
| set_erase_fail_i | input | 1 | Erase-failure set pulse |
| set_prog_fail_i | input | 1 | Program-failure set pulse |
| set_vpp_low_i | input | 1 | Supply-below-lockout set pulse |
| set_protect_i | input | 1 | Protected-block access set pulse |
| clear_i | input | 1 | Clear command for the sticky flags |
| ce_n_i | input | 1 | Chip enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| status_o | output | 8 | Live status word |
| read_o | output | 8 | Bus snapshot of the status word |

## Verification
The snapshot-stability property assumes that the chip-enable and output-enable inputs are both high while reset is applied. Otherwise a capture could fall on the first edge after reset and look like a change during a hold. Every set and clear input is assumed to be a synchronous level sampled at the clock. The stimulus changes all inputs only on falling clock edges and keeps both enables high through every reset. It never changes the status word on the same edge at which it expects a capture.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;
    localparam int STAT_W  = 8;
    localparam int ERR_N   = 4;
    localparam int B_READY = 7;
    localparam int B_ESUSP = 6;
    localparam int B_EFAIL = 5;
    localparam int B_PFAIL = 4;
    localparam int B_VLOW  = 3;
    localparam int B_PSUSP = 2;
    localparam int B_PROT  = 1;
    localparam logic [STAT_W-1:0] RESET_WORD = 8'h80;

    typedef enum logic {
        SNAP_OPEN,
        SNAP_HELD
    } snap_state_t;
endpackage

// File: rtl/flash_sticky_bits.sv
module flash_sticky_bits #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic         clr_i,
    output logic [N-1:0] flag_o
);
    // One cell per flag; set has priority over clear.
    for (genvar i = 0; i < N; i++) begin : g_cell
        logic cell_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cell_q <= 1'b0;
            else if (set_i[i])
                cell_q <= 1'b1;
            else if (clr_i)
                cell_q <= 1'b0;
        end
        assign flag_o[i] = cell_q;
    end
endmodule

// File: rtl/flash_snap_fsm.sv
module flash_snap_fsm
    import flash_stat_pkg::*;
#(
    parameter int                W         = STAT_W,
    parameter logic [W-1:0]      RESET_VAL = RESET_WORD
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ce_n_i,
    input  logic         oe_n_i,
    input  logic [W-1:0] live_i,
    output logic [W-1:0] snap_o
);
    snap_state_t state_q, state_d;
    logic        capture;
    logic        both_low;

    assign both_low = !ce_n_i && !oe_n_i;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= SNAP_OPEN;
        else
            state_q <= state_d;
    end

    // Next state and capture strobe
    always_comb begin
        state_d = state_q;
        capture = 1'b0;
        unique case (state_q)
            SNAP_OPEN: begin
                if (both_low) begin
                    state_d = SNAP_HELD;     // T_CAPTURE
                    capture = 1'b1;
                end
            end
            SNAP_HELD: begin
                if (!both_low)
                    state_d = SNAP_OPEN;     // T_RELEASE
            end
            default: state_d = SNAP_OPEN;
        endcase
    end

    // Snapshot data register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            snap_o <= RESET_VAL;
        else if (capture)
            snap_o <= live_i;
    end
endmodule

// File: rtl/flash_status_reg.sv
module flash_status_reg
    import flash_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy_i,
    input  logic              prog_susp_i,
    input  logic              erase_susp_i,
    input  logic              set_erase_fail_i,
    input  logic              set_prog_fail_i,
    input  logic              set_vpp_low_i,
    input  logic              set_protect_i,
    input  logic              clear_i,
    input  logic              ce_n_i,
    input  logic              oe_n_i,
    output logic [STAT_W-1:0] status_o,
    output logic [STAT_W-1:0] read_o
);
    logic             ready_q;
    logic             esusp_q;
    logic             psusp_q;
    logic [ERR_N-1:0] err_set;
    logic [ERR_N-1:0] err_flag;

    // Level flags, registered once
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ready_q <= 1'b1;
            esusp_q <= 1'b0;
            psusp_q <= 1'b0;
        end else begin
            ready_q <= !busy_i;
            esusp_q <= erase_susp_i;
            psusp_q <= prog_susp_i;
        end
    end

    // err index: 3 erase fail, 2 program fail, 1 supply low, 0 protect
    assign err_set = {set_erase_fail_i, set_prog_fail_i, set_vpp_low_i, set_protect_i};

    flash_sticky_bits #(.N(ERR_N)) u_sticky (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (err_set),
        .clr_i  (clear_i),
        .flag_o (err_flag)
    );

    always_comb begin
        status_o          = '0;
        status_o[B_READY] = ready_q;
        status_o[B_ESUSP] = esusp_q;
        status_o[B_EFAIL] = err_flag[3];
        status_o[B_PFAIL] = err_flag[2];
        status_o[B_VLOW]  = err_flag[1];
        status_o[B_PSUSP] = psusp_q;
        status_o[B_PROT]  = err_flag[0];
    end

    flash_snap_fsm #(.W(STAT_W), .RESET_VAL(RESET_WORD)) u_snap (
        .clk    (clk),
        .rst_n  (rst_n),
        .ce_n_i (ce_n_i),
        .oe_n_i (oe_n_i),
        .live_i (status_o),
        .snap_o (read_o)
    );
endmodule

// File: rtl/flash_status_reg_chk.sv
module flash_status_reg_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy_i,
    input logic       erase_susp_i,
    input logic       set_erase_fail_i,
    input logic       set_protect_i,
    input logic       clear_i,
    input logic       ce_n_i,
    input logic       oe_n_i,
    input logic [7:0] status_o,
    input logic [7:0] read_o
);
    a_r1_busy_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> !status_o[7]);

    a_r2_erase_susp_seen: assert property (@(posedge clk) disable iff (!rst_n)
        erase_susp_i |=> status_o[6]);

    a_r3_erase_fail_set: assert property (@(posedge clk) disable iff (!rst_n)
        set_erase_fail_i |=> status_o[5]);

    a_r4_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> ((status_o & 8'h3A) & $past(status_o & 8'h3A)) == $past(status_o & 8'h3A));

    a_r6_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (set_protect_i && clear_i) |=> status_o[1]);

    a_r7_bit0_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !status_o[0] && !read_o[0]);

    a_r9_snapshot_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n_i && !oe_n_i && $past(!ce_n_i && !oe_n_i) && $past(rst_n)) |=> $stable(read_o));

    a_r10_reset_word: assert property (@(posedge clk)
        $rose(rst_n) |-> (status_o == 8'h80 && read_o == 8'h80));
endmodule

bind flash_status_reg flash_status_reg_chk u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .busy_i           (busy_i),
    .erase_susp_i     (erase_susp_i),
    .set_erase_fail_i (set_erase_fail_i),
    .set_protect_i    (set_protect_i),
    .clear_i          (clear_i),
    .ce_n_i           (ce_n_i),
    .oe_n_i           (oe_n_i),
    .status_o         (status_o),
    .read_o           (read_o)
);

// File: tb/flash_status_reg_test.sv
module flash_status_reg_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       busy_i = 1'b0, prog_susp_i = 1'b0, erase_susp_i = 1'b0;
    logic       set_erase_fail_i = 1'b0, set_prog_fail_i = 1'b0;
    logic       set_vpp_low_i = 1'b0, set_protect_i = 1'b0, clear_i = 1'b0;
    logic       ce_n_i = 1'b1, oe_n_i = 1'b1;
    logic [7:0] status_o, read_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    flash_status_reg uut (.*);

    // {busy, psusp, esusp, set_efail, set_pfail, set_vlow, set_prot, clear, expected status}
    localparam logic [15:0] VEC [12] = '{
        16'h8000, // busy -> not ready (R1)
        16'h9020, // erase fail pulse (R3)
        16'h00A0, // idle, flag kept (R4)
        16'h8020, // new operation keeps flag (R4)
        16'h0180, // clear (R5)
        16'h0C98, // program fail + supply low (R3)
        16'h029A, // protect violation (R3)
        16'h0382, // protect + clear same cycle (R6)
        16'h20C2, // erase suspended (R2)
        16'h0082, // erase resumed (R2)
        16'h4086, // program suspended (R2)
        16'h0180  // clear + program resumed (R5, R2)
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [7:0] c);
        {busy_i, prog_susp_i, erase_susp_i, set_erase_fail_i, set_prog_fail_i,
         set_vpp_low_i, set_protect_i, clear_i} = c;
    endtask

    // Apply at negedge, one posedge, sample 5 ns after it, drop pulses at next negedge
    task automatic cycle_pulses();
        @(posedge clk); #5;
    endtask

    task automatic idle_next();
        @(negedge clk);
        {set_erase_fail_i, set_prog_fail_i, set_vpp_low_i, set_protect_i, clear_i} = '0;
    endtask

    initial begin
        #(20 * 100000);
        failures++;
        $display("FAIL watchdog expired");
        if (!done) begin
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10 status in reset", status_o, 8'h80);
        check("R10 read in reset", read_o, 8'h80);
        rst_n = 1'b1;

        // Vector table
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            drive(VEC[i][15:8]);
            cycle_pulses();
            check("R1 R2 R3 R4 R5 R6 R7 vector", status_o, VEC[i][7:0]);
        end
        idle_next();
        check("R9 read unchanged with enables high", read_o, 8'h80);

        // Snapshot: status 80h, set protect flag -> 82h
        busy_i = 1'b0; prog_susp_i = 1'b0; erase_susp_i = 1'b0;
        set_protect_i = 1'b1;
        cycle_pulses();
        idle_next();
        check("R3 protect flag", status_o, 8'h82);
        ce_n_i = 1'b0; oe_n_i = 1'b0;
        cycle_pulses();
        check("R8 capture on both low", read_o, 8'h82);
        idle_next();
        set_erase_fail_i = 1'b1;
        cycle_pulses();
        idle_next();
        check("R3 erase fail while held", status_o, 8'hA2);
        check("R9 snapshot held", read_o, 8'h82);
        busy_i = 1'b1;
        cycle_pulses();
        check("R9 snapshot still held", read_o, 8'h82);
        @(negedge clk);
        oe_n_i = 1'b1;
        cycle_pulses();
        check("R9 release keeps old value", read_o, 8'h82);
        @(negedge clk);
        oe_n_i = 1'b0;
        cycle_pulses();
        check("R8 recapture after toggle", read_o, 8'h22);
        @(negedge clk);
        ce_n_i = 1'b1; busy_i = 1'b0;
        cycle_pulses();
        @(negedge clk);
        ce_n_i = 1'b0; oe_n_i = 1'b1;
        cycle_pulses();
        check("R8 no capture with output enable high", read_o, 8'h22);
        @(negedge clk);
        ce_n_i = 1'b1;
        check("R7 bit0 of read", {7'b0, read_o[0]}, 8'h00);

        // Hardware reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        #5;
        check("R10 status after reset", status_o, 8'h80);
        check("R10 read after reset", read_o, 8'h80);
        @(negedge clk);
        rst_n = 1'b1;
        busy_i = 1'b1;
        cycle_pulses();
        check("R1 busy after reset", status_o, 8'h00);
        @(negedge clk);
        busy_i = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule